// File: doc/BRIEF.md
# SerDes Mode and Direction Controller

This block sits beside the datapath of a bidirectional parallel-to-serial link and turns two mode pins and a direction input into the controls that datapath needs. It selects serializer or deserializer operation, and it gives the reference-rate range to the clocking logic. It holds the datapath in reset during power-down. It also decides which side drives the bidirectional parallel pins, and it gates the parallel input buffers when they are not in use. The inverted direction output is a purely combinational pass-through, so a second device can follow this one across a turnaround.

A three-state machine is the centre of the block. The states are `ST_PWRDN` (mode pins 00), `ST_SER` (mode pins non-zero, direction high) and `ST_DES` (mode pins non-zero, direction low). Its transitions are:
- power-up to serializer (`ST_PWRDN` to `ST_SER`)
- power-up to deserializer (`ST_PWRDN` to `ST_DES`)
- turnaround to deserializer (`ST_SER` to `ST_DES`)
- turnaround to serializer (`ST_DES` to `ST_SER`)
- power-down (any state to `ST_PWRDN`)

All mode-dependent enables come from registers, so a change on the pins takes effect at the next clock edge.

The block also holds the dedicated-output word, which is kept across turnarounds. It keeps a sticky serializer clock-source flag as well. After power-up the bit clock comes from the incoming clock pair. The flag moves to the reference clock once an activity detector counts enough reference edges inside one window of the free-running clock. Only a power-down moves it back.

Top module: `serdes_modectl`

## Requirements
- R1: After a clock edge that samples `mode_sel` = 00, and in reset, the outputs take the power-down state: `core_rst_n`, `ser_en`, `des_en`, `par_oe`, `par_in_en`, `lvcmos_oe`, `wclk_hold_hi`, `half_rate`, `rate_sel`, `ded_out` and `clk_src_ref` are all 0.
- R2: After each edge with `mode_sel` non-zero, `rate_sel` equals the sampled `mode_sel`. Here 01 is the low range, 10 the middle range and 11 the high range. `half_rate` is 1 only for 11.
- R3: With `mode_sel` non-zero, `dir_in` = 1 gives `ser_en` = 1 and `des_en` = 0, and `dir_in` = 0 gives the reverse. The two are never high together.
- R4: `dir_out` is always the inverse of `dir_in`, with no clock involved, and this includes power-down.
- R5: `par_oe` (drive the bidirectional pins) is 1 only in deserializer operation. `par_in_en` (parallel input buffers on) is 1 only in serializer operation.
- R6: In serializer operation `wclk_hold_hi` is 1. `lvcmos_oe` is 1 in every powered state.
- R7: `ded_out` loads `ded_in` on an edge where `ded_stb` = 1 and the registered state is deserializer. It keeps its value through serializer periods and turnarounds, and a later deserializer capture overwrites it.
- R8: `clk_src_ref` becomes 1 once at least `MIN_EDGES` rising edges of `ref_lvl` fall within one `WIN_CYC`-cycle window. Sparser edges, or none, leave it at 0.
- R9: Once `clk_src_ref` is 1 it stays 1 when `ref_lvl` stops, and through mode and direction changes. It clears only on power-down.
- R10: A change on `mode_sel` or `dir_in` does not alter the registered outputs before the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mode pins: 00 power-down, 01/10/11 rate ranges |
| dir_in | input | 1 | Direction: 1 serializer, 0 deserializer |
| ref_lvl | input | 1 | Reference clock level, sampled for activity |
| ded_in | input | DED_W | Dedicated word from the deserializer datapath |
| ded_stb | input | 1 | Word strobe for the dedicated word |
| dir_out | output | 1 | Inverted direction, combinational |
| core_rst_n | output | 1 | Datapath reset, low in power-down |
| ser_en | output | 1 | Serializer path enable |
| des_en | output | 1 | Deserializer path enable |
| par_oe | output | 1 | Output enable of the bidirectional parallel pins |
| par_in_en | output | 1 | Parallel input buffer enable |
| lvcmos_oe | output | 1 | Enable of dedicated outputs and word clock |
| wclk_hold_hi | output | 1 | Force the word clock output high |
| rate_sel | output | 2 | Registered rate range |
| half_rate | output | 1 | Serial rate halved |
| clk_src_ref | output | 1 | Bit clock from reference (1) or clock pair (0) |
| ded_out | output | DED_W | Held dedicated output word |

## Verification
A wrong state-register value shows at the ports one edge after the inputs that caused it. The symptoms are enables that disagree with the pins, `par_oe` and `par_in_en` both high, or a datapath reset that should have been released. A dedicated-output register that captures outside deserializer periods changes `ded_out` during a serializer period, and that change is visible at once. A detector or latch fault shows as `clk_src_ref` rising under sparse edges, falling when the reference stops, or surviving a power-down. The last of these is visible one edge after the mode pins return to 00.

// File: rtl/modectl_pkg.sv
package modectl_pkg;
    typedef enum logic [1:0] {
        ST_PWRDN = 2'd0,
        ST_SER   = 2'd1,
        ST_DES   = 2'd2
    } mctl_state_e;

    localparam logic [1:0] MODE_OFF  = 2'b00;
    localparam logic [1:0] MODE_HALF = 2'b11;
endpackage

// File: rtl/modectl_actdet.sv
module modectl_actdet #(
    parameter int WIN_CYC   = 64,
    parameter int MIN_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ref_lvl,
    output logic act_pulse
);
    localparam int WW = $clog2(WIN_CYC);
    localparam int EW = $clog2(MIN_EDGES + 1);

    logic [2:0]    sync_q;
    logic [WW-1:0] win_q;
    logic [EW-1:0] cnt_q;
    logic          edge_w;
    logic          wrap_w;

    assign edge_w    = sync_q[1] & ~sync_q[2];
    assign wrap_w    = (win_q == WW'(WIN_CYC - 1));
    assign act_pulse = edge_w && !wrap_w && (cnt_q == EW'(MIN_EDGES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            win_q  <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            sync_q <= '0;
            win_q  <= '0;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[1:0], ref_lvl};
            win_q  <= wrap_w ? '0 : win_q + 1'b1;
            if (wrap_w)
                cnt_q <= edge_w ? EW'(1) : '0;
            else if (edge_w && (cnt_q < EW'(MIN_EDGES)))
                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/modectl_fsm.sv
module modectl_fsm
    import modectl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       dir_in,
    output logic       core_rst_n,
    output logic       ser_en,
    output logic       des_en,
    output logic       par_oe,
    output logic       par_in_en,
    output logic       lvcmos_oe,
    output logic       wclk_hold_hi,
    output logic [1:0] rate_sel,
    output logic       half_rate
);
    mctl_state_e state_q, state_d;
    logic [1:0]  rate_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRDN: if (mode_sel != MODE_OFF) state_d = dir_in ? ST_SER : ST_DES;
            ST_SER:   if (mode_sel == MODE_OFF) state_d = ST_PWRDN;
                      else if (!dir_in)         state_d = ST_DES;
            ST_DES:   if (mode_sel == MODE_OFF) state_d = ST_PWRDN;
                      else if (dir_in)          state_d = ST_SER;
            default:  state_d = ST_PWRDN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWRDN;
            rate_q  <= MODE_OFF;
        end else begin
            state_q <= state_d;
            rate_q  <= mode_sel;
        end
    end

    always_comb begin
        core_rst_n   = 1'b0;
        ser_en       = 1'b0;
        des_en       = 1'b0;
        par_oe       = 1'b0;
        par_in_en    = 1'b0;
        lvcmos_oe    = 1'b0;
        wclk_hold_hi = 1'b0;
        unique case (state_q)
            ST_PWRDN: ;
            ST_SER: begin
                core_rst_n   = 1'b1;
                ser_en       = 1'b1;
                par_in_en    = 1'b1;
                lvcmos_oe    = 1'b1;
                wclk_hold_hi = 1'b1;
            end
            ST_DES: begin
                core_rst_n = 1'b1;
                des_en     = 1'b1;
                par_oe     = 1'b1;
                lvcmos_oe  = 1'b1;
            end
            default: ;
        endcase
        rate_sel  = rate_q;
        half_rate = (rate_q == MODE_HALF);
    end
endmodule

// File: rtl/modectl_dedhold.sv
module modectl_dedhold #(
    parameter int DED_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cap_en,
    input  logic [DED_W-1:0] din,
    output logic [DED_W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dout <= '0;
        else if (clr)    dout <= '0;
        else if (cap_en) dout <= din;
    end
endmodule

// File: rtl/serdes_modectl.sv
module serdes_modectl
    import modectl_pkg::*;
#(
    parameter int DED_W     = 2,
    parameter int WIN_CYC   = 64,
    parameter int MIN_EDGES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             dir_in,
    input  logic             ref_lvl,
    input  logic [DED_W-1:0] ded_in,
    input  logic             ded_stb,
    output logic             dir_out,
    output logic             core_rst_n,
    output logic             ser_en,
    output logic             des_en,
    output logic             par_oe,
    output logic             par_in_en,
    output logic             lvcmos_oe,
    output logic             wclk_hold_hi,
    output logic [1:0]       rate_sel,
    output logic             half_rate,
    output logic             clk_src_ref,
    output logic [DED_W-1:0] ded_out
);
    logic pd_req;
    logic act_pulse;
    logic src_q;

    assign dir_out = ~dir_in;
    assign pd_req  = (mode_sel == MODE_OFF);

    modectl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sel     (mode_sel),
        .dir_in       (dir_in),
        .core_rst_n   (core_rst_n),
        .ser_en       (ser_en),
        .des_en       (des_en),
        .par_oe       (par_oe),
        .par_in_en    (par_in_en),
        .lvcmos_oe    (lvcmos_oe),
        .wclk_hold_hi (wclk_hold_hi),
        .rate_sel     (rate_sel),
        .half_rate    (half_rate)
    );

    modectl_actdet #(.WIN_CYC(WIN_CYC), .MIN_EDGES(MIN_EDGES)) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pd_req),
        .ref_lvl   (ref_lvl),
        .act_pulse (act_pulse)
    );

    modectl_dedhold #(.DED_W(DED_W)) u_ded (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pd_req),
        .cap_en (des_en && ded_stb),
        .din    (ded_in),
        .dout   (ded_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         src_q <= 1'b0;
        else if (pd_req)    src_q <= 1'b0;
        else if (act_pulse) src_q <= 1'b1;
    end

    assign clk_src_ref = src_q;
endmodule

// File: rtl/modectl_sva.sv
module modectl_sva #(
    parameter int DED_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_sel,
    input logic             dir_in,
    input logic             ded_stb,
    input logic             core_rst_n,
    input logic             ser_en,
    input logic             des_en,
    input logic             par_oe,
    input logic             par_in_en,
    input logic             lvcmos_oe,
    input logic             wclk_hold_hi,
    input logic [1:0]       rate_sel,
    input logic             clk_src_ref,
    input logic [DED_W-1:0] ded_out
);
    p_pwrdn_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00) |=> (!core_rst_n && !ser_en && !des_en && !lvcmos_oe
                                 && ded_out == '0 && !clk_src_ref));

    p_rate_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != 2'b00) |=> (rate_sel == $past(mode_sel)));

    p_dir_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ser_en, des_en}));

    p_dir_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != 2'b00 && dir_in) |=> ser_en);

    p_par_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> (!par_in_en && !wclk_hold_hi));

    p_oe_powered_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en || des_en) |-> lvcmos_oe);

    p_ded_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(des_en && ded_stb) && mode_sel != 2'b00) |=> $stable(ded_out));

    p_src_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_src_ref && mode_sel != 2'b00) |=> clk_src_ref);
endmodule

bind serdes_modectl modectl_sva #(.DED_W(DED_W)) sva_i (.*);

// File: tb/serdes_modectl_tb_top.sv
module serdes_modectl_tb_top;
    localparam int DED_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode_sel = 2'b00;
    logic             dir_in = 1'b1;
    logic             ref_lvl = 1'b0;
    logic [DED_W-1:0] ded_in = '0;
    logic             ded_stb = 1'b0;
    logic             dir_out, core_rst_n, ser_en, des_en, par_oe, par_in_en;
    logic             lvcmos_oe, wclk_hold_hi, half_rate, clk_src_ref;
    logic [1:0]       rate_sel;
    logic [DED_W-1:0] ded_out;

    int tests = 0;
    int fails = 0;
    int ref_half = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [12:0] v;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    logic [1:0]       m_mode = 2'b00;
    logic             m_dir  = 1'b1;
    logic [DED_W-1:0] m_ded  = '0;
    logic             m_src  = 1'b0;
    logic [12:0]      last_v = '0;

    always #4 clk = ~clk;

    serdes_modectl #(.DED_W(DED_W), .WIN_CYC(64), .MIN_EDGES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .dir_in(dir_in),
        .ref_lvl(ref_lvl), .ded_in(ded_in), .ded_stb(ded_stb),
        .dir_out(dir_out), .core_rst_n(core_rst_n), .ser_en(ser_en),
        .des_en(des_en), .par_oe(par_oe), .par_in_en(par_in_en),
        .lvcmos_oe(lvcmos_oe), .wclk_hold_hi(wclk_hold_hi),
        .rate_sel(rate_sel), .half_rate(half_rate),
        .clk_src_ref(clk_src_ref), .ded_out(ded_out)
    );

    function automatic logic [12:0] act_vec();
        return {core_rst_n, ser_en, des_en, par_oe, par_in_en, lvcmos_oe,
                wclk_hold_hi, half_rate, rate_sel, ded_out, clk_src_ref};
    endfunction

    function automatic logic [12:0] exp_vec(logic [1:0] md, logic dr,
                                            logic [DED_W-1:0] dd, logic sr);
        logic on, s, d;
        on = (md != 2'b00);
        s  = on && dr;
        d  = on && !dr;
        return {on, s, d, d, s, on, s, (md == 2'b11), md, dd, sr};
    endfunction

    task automatic check(string req, logic [12:0] act, logic [12:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // driver: drives at negedge, checks the pre-edge hold and pass-through, queues expected
    task automatic drive(logic [1:0] md, logic dr, logic [DED_W-1:0] din,
                         logic stb, string tag);
        logic was_des;
        exp_t e;
        @(negedge clk);
        mode_sel = md;
        dir_in   = dr;
        ded_in   = din;
        ded_stb  = stb;
        #1;
        check("R4 dir_out", {12'b0, dir_out}, {12'b0, ~dr});
        check("R10 hold before edge", act_vec(), last_v);
        was_des = (m_mode != 2'b00) && !m_dir;
        if (md == 2'b00) begin
            m_ded = '0;
            m_src = 1'b0;
        end else if (was_des && stb) begin
            m_ded = din;
        end
        m_mode = md;
        m_dir  = dr;
        e.v    = exp_vec(md, dr, m_ded, m_src);
        e.tag  = tag;
        last_v = e.v;
        exp_q.push_back(e);
    endtask

    // monitor: compares after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, act_vec(), e.v);
            end
        end
    end

    // reference level generator
    initial begin
        forever begin
            if (ref_half == 0) @(negedge clk);
            else begin
                repeat (ref_half) @(negedge clk);
                ref_lvl = ~ref_lvl;
            end
        end
    end

    initial begin
        #(8 * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog: act=running exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", act_vec(), 13'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", act_vec(), 13'b0);

        drive(2'b01, 1'b1, 2'b00, 1'b0, "R2 R3 R5 R6 serializer low range");
        drive(2'b10, 1'b1, 2'b00, 1'b0, "R2 middle range");
        drive(2'b11, 1'b1, 2'b00, 1'b0, "R2 half rate");
        drive(2'b11, 1'b0, 2'b00, 1'b0, "R3 R5 turnaround to deserializer");
        drive(2'b11, 1'b0, 2'b10, 1'b1, "R7 capture in deserializer");
        drive(2'b11, 1'b1, 2'b01, 1'b0, "R7 turnaround to serializer keeps word");
        drive(2'b11, 1'b1, 2'b01, 1'b1, "R7 strobe ignored in serializer");
        drive(2'b10, 1'b1, 2'b01, 1'b1, "R7 strobe ignored after range change");
        drive(2'b01, 1'b0, 2'b01, 1'b0, "R7 back to deserializer keeps word");
        drive(2'b01, 1'b0, 2'b01, 1'b1, "R7 later capture overwrites");
        drive(2'b00, 1'b0, 2'b11, 1'b1, "R1 power-down clears");
        drive(2'b00, 1'b1, 2'b11, 1'b0, "R1 R4 power-down with dir high");
        drive(2'b10, 1'b0, 2'b00, 1'b0, "R3 power-up to deserializer");
        drive(2'b01, 1'b1, 2'b00, 1'b0, "R3 serializer for clock source");
        repeat (3) @(negedge clk);

        ref_half = 40;
        repeat (300) @(negedge clk);
        check("R8 sparse edges keep pair", {12'b0, clk_src_ref}, 13'd0);
        ref_half = 2;
        repeat (200) @(negedge clk);
        check("R8 dense edges pick reference", {12'b0, clk_src_ref}, 13'd1);
        m_src    = 1'b1;
        last_v   = exp_vec(m_mode, m_dir, m_ded, m_src);
        ref_half = 0;
        repeat (300) @(negedge clk);
        check("R9 stays after reference stops", {12'b0, clk_src_ref}, 13'd1);
        drive(2'b11, 1'b1, 2'b00, 1'b0, "R9 sticky across range change");
        drive(2'b11, 1'b0, 2'b00, 1'b0, "R9 sticky across turnaround");
        drive(2'b00, 1'b0, 2'b00, 1'b0, "R9 R1 power-down clears source");
        drive(2'b01, 1'b1, 2'b00, 1'b0, "R8 power-up on pair");
        repeat (200) @(negedge clk);
        check("R8 no reference keeps pair", {12'b0, clk_src_ref}, 13'd0);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule